// File: doc/BRIEF.md
# Reloadable Countdown Timer

This block is a down-counting timer that sits on a simple single-cycle register bus. Software programs a start value and a small control word. While the timer is enabled, the counter steps down by one on each pulse of the tick rate it has selected. One of two tick enables drives the count: a slow tick at about 2 kHz or a fast tick at about 508 kHz. Both ticks are generated outside the block and arrive as one-cycle enable pulses.

When the count reaches zero, the block latches an interrupt request. In periodic mode the count then restarts from the stored start value. In one-shot mode the count stays at zero until software writes a new start value. Writing the start value also replaces the live count at once, even while the timer is running. Software drops the interrupt by writing any data to a dedicated clear address.

Top module: `ctmr_top`

## Requirements
- R1: After reset the start value, the live count and the control word all read 0, and `irq` is low.
- R2: A write to offset 0x0 stores the start value and sets the live count to the written data on the next cycle, whether or not the timer is enabled.
- R3: The control word at offset 0x8 keeps enable at bit 7, periodic mode at bit 6 and rate select at bit 3. Every other bit of the control word reads 0, and offset 0xC reads 0.
- R4: While the enable bit is 0, ticks leave the count unchanged.
- R5: A rate select of 0 counts on `tick_slow` only, and a rate select of 1 counts on `tick_fast` only. Pulses on the tick that is not selected have no effect.
- R6: Each selected tick lowers a nonzero count by one. A tick that takes the count from 1 to 0 sets `irq`.
- R7: In periodic mode (bit 6 = 1), the tick that expires the count loads the count from the stored start value instead of leaving it at 0.
- R8: In one-shot mode (bit 6 = 0), the count stays at 0 after expiry, and further ticks raise no new interrupt.
- R9: A write of any data to offset 0xC drops `irq` on the next cycle.
- R10: If an expiry and a write to the clear offset happen in the same cycle, `irq` stays high.
- R11: If a start-value write and a selected tick happen in the same cycle, the count takes the written value and no expiry occurs.
- R12: The live count at offset 0x4 is read only: a write there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 marks the access as a write, 0 as a read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| tick_slow | input | 1 | Slow-rate tick enable |
| tick_fast | input | 1 | Fast-rate tick enable |
| irq | output | 1 | Latched interrupt request |

## Verification
Some properties are checked on every cycle:
- the single-step decrement;
- the hold while disabled;
- the forced load of the count;
- the one-shot hold at zero;
- the interrupt latch, which holds, clears and lets an expiry override a clear;
- the upper control bits reading zero.

Other behaviour is visible only in the bench's scenarios:
- that the unselected tick rate is ignored;
- that a periodic expiry restores the stored start value;
- that writes to the read-only count are dropped;
- the exact register read-back values;
- the same-cycle start-value write against a tick.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned CSEL_BIT = 3;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic enable;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_val,
  output logic [DATA_W-1:0] start_val,
  output ctrl_t             ctrl,
  output logic              start_we,
  output logic              clear_we,
  output logic [DATA_W-1:0] bus_rdata
);
  reg_sel_e          sel;
  logic              ctrl_we;
  logic [DATA_W-1:0] start_d;
  ctrl_t             ctrl_d;

  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign start_we = bus_sel && bus_wr && (sel == SEL_START);
  assign ctrl_we  = bus_sel && bus_wr && (sel == SEL_CTRL);
  assign clear_we = bus_sel && bus_wr && (sel == SEL_CLEAR);

  always_comb begin
    start_d = start_val;
    ctrl_d  = ctrl;
    if (start_we) start_d = bus_wdata;
    if (ctrl_we) begin
      ctrl_d.enable   = bus_wdata[EN_BIT];
      ctrl_d.periodic = bus_wdata[MODE_BIT];
      ctrl_d.fast     = bus_wdata[CSEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_val <= '0;
      ctrl      <= '0;
    end else begin
      start_val <= start_d;
      ctrl      <= ctrl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_START: bus_rdata = start_val;
      SEL_COUNT: bus_rdata = count_val;
      SEL_CTRL: begin
        bus_rdata[EN_BIT]   = ctrl.enable;
        bus_rdata[MODE_BIT] = ctrl.periodic;
        bus_rdata[CSEL_BIT] = ctrl.fast;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R3: only the three control fields may read back as ones
  a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (bus_rdata[DATA_W-1:EN_BIT+1] == '0));
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_data,
  input  logic [DATA_W-1:0] start_val,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              tick_sel;
  logic              step;
  logic [DATA_W-1:0] count_d;
  logic [DATA_W-1:0] restart;

  assign tick_sel = ctrl.fast ? tick_fast : tick_slow;
  assign step     = ctrl.enable && tick_sel;
  assign restart  = ctrl.periodic ? start_val : '0;

  always_comb begin
    count_d = count;
    expire  = 1'b0;
    if (start_we) begin
      count_d = start_data;
    end else if (step) begin
      if (count == ONE) begin
        expire  = 1'b1;
        count_d = restart;
      end else if (count == '0) begin
        count_d = restart;
      end else begin
        count_d = count - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R2: a start write forces the count
  a_r2_forced_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> (count == $past(start_data)));
  // R4: no movement while disabled
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !start_we) |=> $stable(count));
  // R6: one step per selected tick above one
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start_we && count > ONE) |=> (count == $past(count) - ONE));
  // R8: one-shot mode stays at zero
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !ctrl.periodic && !start_we) |=> (count == '0));
endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear_we,
  output logic irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (expire)        irq_d = 1'b1;
    else if (clear_we) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R10: expiry overrides a clear in the same cycle
  a_r10_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  // R9: a clear without expiry drops the request
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_we && !expire) |=> !irq);
  // R9: the latch holds with neither event
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_we && !expire) |=> $stable(irq));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              irq
);
  logic [DATA_W-1:0] count_val;
  logic [DATA_W-1:0] start_val;
  ctrl_t             ctrl;
  logic              start_we;
  logic              clear_we;
  logic              expire;

  ctmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_val (count_val),
    .start_val (start_val),
    .ctrl      (ctrl),
    .start_we  (start_we),
    .clear_we  (clear_we),
    .bus_rdata (bus_rdata)
  );

  ctmr_counter #(.DATA_W(DATA_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .tick_slow  (tick_slow),
    .tick_fast  (tick_fast),
    .start_we   (start_we),
    .start_data (bus_wdata),
    .start_val  (start_val),
    .count      (count_val),
    .expire     (expire)
  );

  ctmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .clear_we (clear_we),
    .irq      (irq)
  );
endmodule

// File: tb/test_ctmr_top.sv
module test_ctmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ctmr_top i_ctmr_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic tick(input logic fast);
    @(negedge clk);
    if (fast) tick_fast = 1; else tick_slow = 1;
    @(negedge clk);
    tick_fast = 0; tick_slow = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 start", v, 0);
    rd(4'h4, v); chk("R1 count", v, 0);
    rd(4'h8, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R3 ctrl all ones", v, 32'h0000_00C8);
    rd(4'hC, v); chk("R3 clear reads zero", v, 0);
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R3 ctrl zero", v, 0);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    wr(4'h0, 5);
    rd(4'h4, v); chk("R2 load idle", v, 5);
    rd(4'h0, v); chk("R2 start stored", v, 5);
    wr(4'h4, 99);
    rd(4'h4, v); chk("R12 count read only", v, 5);
    for (int i = 0; i < 3; i++) begin tick(0); tick(1); end
    rd(4'h4, v); chk("R4 disabled hold", v, 5);
  endtask

  task automatic t_oneshot_slow();
    logic [31:0] v;
    wr(4'h0, 3);
    wr(4'h8, 32'h80);
    tick(1); tick(1);
    rd(4'h4, v); chk("R5 fast ignored", v, 3);
    tick(0);
    rd(4'h4, v); chk("R6 step", v, 2);
    tick(0);
    chk("R6 no irq early", {31'b0, irq}, 0);
    tick(0);
    rd(4'h4, v); chk("R6 reach zero", v, 0);
    chk("R6 irq set", {31'b0, irq}, 1);
    tick(0); tick(0);
    rd(4'h4, v); chk("R8 hold zero", v, 0);
    wr(4'hC, 32'h1234);
    chk("R9 clear", {31'b0, irq}, 0);
    tick(0);
    chk("R8 no new irq", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic_fast();
    logic [31:0] v;
    wr(4'h8, 32'hC8);
    wr(4'h0, 2);
    tick(1);
    rd(4'h4, v); chk("R6 fast step", v, 1);
    tick(1);
    rd(4'h4, v); chk("R7 reload", v, 2);
    chk("R7 irq", {31'b0, irq}, 1);
    tick(0); tick(0);
    rd(4'h4, v); chk("R5 slow ignored", v, 2);
    wr(4'hC, 0);
    chk("R9 clear zero data", {31'b0, irq}, 0);
    wr(4'h0, 7);
    rd(4'h4, v); chk("R2 load while running", v, 7);
    tick(1);
    rd(4'h4, v); chk("R6 after load", v, 6);
  endtask

  task automatic t_races();
    logic [31:0] v;
    wr(4'h0, 1);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'hC; bus_wdata = 32'hDEAD; tick_fast = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_fast = 0;
    chk("R10 expire beats clear", {31'b0, irq}, 1);
    rd(4'h4, v); chk("R7 reload one", v, 1);
    wr(4'hC, 0);
    chk("R9 clear after race", {31'b0, irq}, 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 9; tick_fast = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_fast = 0;
    rd(4'h4, v); chk("R11 load beats tick", v, 9);
    chk("R11 no expiry", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_idle();
    t_oneshot_slow();
    t_periodic_fast();
    t_races();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule